// File: doc/BRIEF.md
# Slave-Mode Up/Down Timer Counter

This block is a general-purpose counter. A 3-bit slave-mode field decides what makes it advance. In the self-timed modes it advances once per clock. It can run freely, run only while an external trigger is high, or start on a trigger rising edge and keep running from then on. In these three modes a software direction bit sets up or down counting, and an enable bit must be set.

In the encoder modes, two channel inputs A and B drive the counter, and the enable and direction bits are not used. The counter can follow edges of A alone, edges of B alone, or every edge of either channel (full quadrature, four counts per encoder cycle). The phase relation between A and B sets the direction.

A programmable preset is the reload point. Counting up past it returns to zero. Counting down from zero loads the preset. Both cases raise a single-cycle wrap pulse. The trigger and both encoder channels are resynchronised to the clock before use.

Top module: `tmr_slave_counter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, the count reads 0 and the wrap output is 0.
- R2: With mode code 0 and enable set, the count changes by one on every clock. The direction bit selects the way: 0 is up, 1 is down.
- R3: In mode codes 0, 5 and 6, a cleared enable bit holds the count unchanged.
- R4: With mode code 5 and enable set, the count advances once per clock while the synchronised trigger is high and holds while it is low. A trigger held high for N clocks yields exactly N counts.
- R5: With mode code 6 and enable set, counting begins two clocks after the trigger rises. It continues after the trigger falls, and later trigger edges do not change the rate. Clearing enable stops it, and setting enable again does not restart it without a new rising edge.
- R6: An up step taken when the count is at or above the preset sets the count to 0. A down step taken at 0 loads the preset. In both cases the wrap output is 1 for exactly the clock in which that new value appears.
- R7: Mode code 3 counts every valid edge of A or B, which gives four counts per encoder cycle. The sequence (A,B) = 00, 10, 11, 01, 00 counts up. The reverse sequence counts down.
- R8: Mode code 1 counts only edges of A, and mode code 2 counts only edges of B. Each gives two counts per encoder cycle, with direction taken from the same phase rule as R7.
- R9: In encoder modes (codes 1, 2, 3) the enable and direction bits have no effect on counting.
- R10: An encoder input change in which A and B both toggle between two synchronised samples produces no count.
- R11: Mode codes 4 and 7 halt the counter whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 3 | Slave-mode code (0 free, 1 A-edges, 2 B-edges, 3 quadrature, 5 gated, 6 triggered) |
| dir_down | input | 1 | Direction for codes 0/5/6: 1 counts down |
| cnt_en | input | 1 | Counter enable for codes 0/5/6 |
| preset | input | CNT_W | Reload / wrap point |
| trig_in | input | 1 | Asynchronous trigger input |
| enc_a | input | 1 | Asynchronous encoder channel A |
| enc_b | input | 1 | Asynchronous encoder channel B |
| count | output | CNT_W | Current counter value |
| wrap | output | 1 | One-clock pulse on wrap-to-zero or reload |

## Verification
The bench builds the counter with an 8-bit count and the default two-stage synchroniser. With an 8-bit count, small presets put both wrap directions a few clocks away from a fresh reset. The two-stage synchroniser fixes the trigger and encoder latency at two clocks, so gated spans and triggered starts can be predicted to the exact cycle. Mode changes are made without a reset in between. This exercises the halt codes and the single-channel encoder codes against edge-history registers that were already running.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
// Package tmr_pkg: slave-mode codes and the step request passed from mode
// control to the counter core. Codes 4 and 7 are unassigned (halt).
package tmr_pkg;
    localparam logic [2:0] SM_FREE      = 3'd0;
    localparam logic [2:0] SM_ENC_A     = 3'd1;
    localparam logic [2:0] SM_ENC_B     = 3'd2;
    localparam logic [2:0] SM_ENC_AB    = 3'd3;
    localparam logic [2:0] SM_GATED     = 3'd5;
    localparam logic [2:0] SM_TRIGGERED = 3'd6;

    // One counting request for the current clock.
    typedef struct packed {
        logic step;   // advance this clock
        logic down;   // 1 = decrement
    } step_req_t;
endpackage

// File: rtl/tmr_sync.sv
`timescale 1ns/1ps
// Module tmr_sync: multi-flop synchroniser for a vector of asynchronous
// inputs. Assumes each bit is independent (no bus coherency implied) and
// STAGES >= 2. Output is the last stage of the chain.
module tmr_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_in;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/tmr_enc_dec.sv
`timescale 1ns/1ps
// Module tmr_enc_dec: quadrature decoder on synchronised channels.
// Detects single-channel changes against the previous sample; a change of
// both channels at once is discarded. Up when A leads B. Which channel's
// edges produce steps is chosen by cnt_a / cnt_b.
module tmr_enc_dec (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   a_s,
    input  logic                   b_s,
    input  logic                   cnt_a,
    input  logic                   cnt_b,
    output tmr_pkg::step_req_t     enc_req
);
    logic a_q, b_q;
    logic a_only, b_only;

    // Keep the previous synchronised sample of both channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
        end else begin
            a_q <= a_s;
            b_q <= b_s;
        end
    end

    assign a_only = (a_s ^ a_q) & ~(b_s ^ b_q);
    assign b_only = (b_s ^ b_q) & ~(a_s ^ a_q);

    // Turn a valid single-channel change into a step and direction.
    always_comb begin
        enc_req.step = (cnt_a & a_only) | (cnt_b & b_only);
        if (a_only) begin
            enc_req.down = (a_s == b_s);
        end else begin
            enc_req.down = (a_s != b_s);
        end
    end
endmodule

// File: rtl/tmr_mode_ctrl.sv
`timescale 1ns/1ps
// Module tmr_mode_ctrl: decodes the slave-mode field into a per-clock step
// request. Holds the trigger edge history and the "started" flag of the
// triggered mode. Inputs are already synchronised.
module tmr_mode_ctrl
    import tmr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic [2:0] mode_sel,
    input  logic      cnt_en,
    input  logic      dir_down,
    input  logic      trig_s,
    input  step_req_t enc_req,
    output logic      cnt_a,
    output logic      cnt_b,
    output step_req_t req
);
    logic trig_q;
    logic started_q;
    logic trig_rise;

    assign trig_rise = trig_s & ~trig_q;
    assign cnt_a = (mode_sel == SM_ENC_A) || (mode_sel == SM_ENC_AB);
    assign cnt_b = (mode_sel == SM_ENC_B) || (mode_sel == SM_ENC_AB);

    // Trigger history and latch of the triggered-mode start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q    <= 1'b0;
            started_q <= 1'b0;
        end else begin
            trig_q <= trig_s;
            if (mode_sel != SM_TRIGGERED || !cnt_en) begin
                started_q <= 1'b0;
            end else if (trig_rise) begin
                started_q <= 1'b1;
            end
        end
    end

    // Select the counting source for the current mode.
    always_comb begin
        req.step = 1'b0;
        req.down = dir_down;
        case (mode_sel)
            SM_FREE:      req.step = cnt_en;
            SM_GATED:     req.step = cnt_en & trig_s;
            SM_TRIGGERED: req.step = cnt_en & (started_q | trig_rise);
            SM_ENC_A, SM_ENC_B, SM_ENC_AB: req = enc_req;
            default:      req.step = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_count_core.sv
`timescale 1ns/1ps
// Module tmr_count_core: the counter register with preset-based wrap.
// Up past (or at) preset goes to 0; down from 0 loads preset; each raises
// a registered one-clock wrap pulse aligned with the new value.
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_req_t        req,
    input  logic [CNT_W-1:0] preset,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Advance, wrap or reload the count on a step request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            wrap  <= 1'b0;
        end else begin
            wrap <= 1'b0;
            if (req.step) begin
                if (req.down) begin
                    if (count == '0) begin
                        count <= preset;
                        wrap  <= 1'b1;
                    end else begin
                        count <= count - ONE;
                    end
                end else begin
                    if (count >= preset) begin
                        count <= '0;
                        wrap  <= 1'b1;
                    end else begin
                        count <= count + ONE;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/tmr_slave_counter.sv
`timescale 1ns/1ps
// Module tmr_slave_counter: top of the slave-mode timer counter.
// Synchronises trigger and encoder inputs, decodes the mode into a step
// request and drives the counter core. Assumes asynchronous trig/enc inputs.
module tmr_slave_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_sel,
    input  logic             dir_down,
    input  logic             cnt_en,
    input  logic [CNT_W-1:0] preset,
    input  logic             trig_in,
    input  logic             enc_a,
    input  logic             enc_b,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam int N_ASYNC = 3;

    logic [N_ASYNC-1:0] sync_q;
    logic               trig_lvl;
    logic               cnt_a, cnt_b;
    step_req_t          enc_req;
    step_req_t          req;

    tmr_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({enc_b, enc_a, trig_in}),
        .q_out (sync_q)
    );

    assign trig_lvl = sync_q[0];

    tmr_enc_dec u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_s     (sync_q[1]),
        .b_s     (sync_q[2]),
        .cnt_a   (cnt_a),
        .cnt_b   (cnt_b),
        .enc_req (enc_req)
    );

    tmr_mode_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .cnt_en   (cnt_en),
        .dir_down (dir_down),
        .trig_s   (trig_lvl),
        .enc_req  (enc_req),
        .cnt_a    (cnt_a),
        .cnt_b    (cnt_b),
        .req      (req)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .preset (preset),
        .count  (count),
        .wrap   (wrap)
    );
endmodule

// File: rtl/tmr_slave_counter_chk.sv
`timescale 1ns/1ps
// Module tmr_slave_counter_chk: temporal properties of the counter, bound
// into tmr_slave_counter.
module tmr_slave_counter_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       mode_sel,
    input logic             dir_down,
    input logic             cnt_en,
    input logic [CNT_W-1:0] preset,
    input logic             trig_lvl,
    input logic [CNT_W-1:0] count,
    input logic             wrap
);
    // R1: reset clears count and wrap
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && !wrap));

    // R2: free-run up step adds one below preset
    p_free_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd0 && cnt_en && !dir_down && count < preset)
        |=> count == $past(count) + CNT_W'(1));

    // R3: cleared enable holds count in self-timed modes
    p_enable_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_sel == 3'd0 || mode_sel == 3'd5 || mode_sel == 3'd6) && !cnt_en)
        |=> $stable(count));

    // R4: gated mode holds while synchronised trigger is low
    p_gate_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd5 && !trig_lvl) |=> $stable(count));

    // R6: wrap only lands on zero or the reload value
    p_wrap_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> (count == '0 || count == $past(preset)));

    // R11: unassigned codes halt the counter
    p_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 3'd4 || mode_sel == 3'd7) |=> $stable(count));
endmodule

bind tmr_slave_counter tmr_slave_counter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_sel (mode_sel),
    .dir_down (dir_down),
    .cnt_en   (cnt_en),
    .preset   (preset),
    .trig_lvl (trig_lvl),
    .count    (count),
    .wrap     (wrap)
);

// File: tb/test_tmr_slave_counter.sv
`timescale 1ns/1ps
// Directed bench for tmr_slave_counter: one task per scenario.
module test_tmr_slave_counter;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       mode_sel = 3'd0;
    logic             dir_down = 1'b0;
    logic             cnt_en = 1'b0;
    logic [CNT_W-1:0] preset = 8'd200;
    logic             trig_in = 1'b0;
    logic             enc_a = 1'b0;
    logic             enc_b = 1'b0;
    logic [CNT_W-1:0] count;
    logic             wrap;

    int n_tests = 0;
    int n_fail  = 0;

    tmr_slave_counter #(.CNT_W(CNT_W), .SYNC_STAGES(2)) i_tmr_slave_counter (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .dir_down(dir_down),
        .cnt_en(cnt_en), .preset(preset), .trig_in(trig_in), .enc_a(enc_a),
        .enc_b(enc_b), .count(count), .wrap(wrap)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Advance n rising edges, then stop on the following falling edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; mode_sel = 3'd0; dir_down = 1'b0; cnt_en = 1'b0;
        preset = 8'd200; trig_in = 1'b0; enc_a = 1'b0; enc_b = 1'b0;
        step(2);
        rst_n = 1'b1;
    endtask

    task automatic enc_move(input logic a, input logic b);
        enc_a = a; enc_b = b;
        step(4);
    endtask

    task automatic enc_cycle_up();
        enc_move(1, 0); enc_move(1, 1); enc_move(0, 1); enc_move(0, 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 count", count, 0);
        chk("R1 wrap", wrap, 0);
    endtask

    task automatic t_free_run();
        do_reset();
        cnt_en = 1'b1;
        step(10);
        chk("R2 up", count, 10);
        dir_down = 1'b1;
        step(4);
        chk("R2 down", count, 6);
        cnt_en = 1'b0;
        step(5);
        chk("R3 hold", count, 6);
    endtask

    task automatic t_wrap();
        do_reset();
        preset = 8'd3; cnt_en = 1'b1;
        step(3);
        chk("R6 at preset", count, 3);
        chk("R6 no wrap yet", wrap, 0);
        step(1);
        chk("R6 up wrap value", count, 0);
        chk("R6 up wrap pulse", wrap, 1);
        step(1);
        chk("R6 after wrap", count, 1);
        chk("R6 pulse one clock", wrap, 0);
        do_reset();
        preset = 8'd3; dir_down = 1'b1; cnt_en = 1'b1;
        step(1);
        chk("R6 down reload", count, 3);
        chk("R6 down wrap pulse", wrap, 1);
        step(1);
        chk("R6 down after", count, 2);
        chk("R6 down pulse one clock", wrap, 0);
    endtask

    task automatic t_gated();
        do_reset();
        mode_sel = 3'd5; cnt_en = 1'b1;
        step(5);
        chk("R4 idle low", count, 0);
        trig_in = 1'b1;
        step(7);
        trig_in = 1'b0;
        step(6);
        chk("R4 N counts", count, 7);
        step(5);
        chk("R4 hold low", count, 7);
        cnt_en = 1'b0; trig_in = 1'b1;
        step(6);
        chk("R3 gated disabled", count, 7);
    endtask

    task automatic t_triggered();
        int c;
        do_reset();
        mode_sel = 3'd6; cnt_en = 1'b1;
        step(5);
        chk("R5 waits for edge", count, 0);
        trig_in = 1'b1;
        step(2);
        trig_in = 1'b0;
        step(10);
        chk("R5 started", count, 10);
        c = count;
        trig_in = 1'b1;
        step(2);
        trig_in = 1'b0;
        step(8);
        chk("R5 retrigger no effect", count, c + 10);
        cnt_en = 1'b0;
        c = count;
        step(5);
        chk("R5 stop on disable", count, c);
        cnt_en = 1'b1;
        step(5);
        chk("R5 no restart without edge", count, c);
    endtask

    task automatic t_quad();
        do_reset();
        mode_sel = 3'd3; cnt_en = 1'b0; dir_down = 1'b1;
        enc_move(1, 0);
        chk("R7 single edge", count, 1);
        enc_move(1, 1); enc_move(0, 1); enc_move(0, 0);
        chk("R7 four per cycle", count, 4);
        enc_cycle_up();
        chk("R9 enable/dir ignored", count, 8);
        enc_move(0, 1); enc_move(1, 1); enc_move(1, 0); enc_move(0, 0);
        chk("R7 B leads down", count, 4);
        enc_move(1, 1);
        chk("R10 both toggle", count, 4);
        enc_move(0, 0);
        chk("R10 both toggle back", count, 4);
    endtask

    task automatic t_single_channel();
        do_reset();
        mode_sel = 3'd1; cnt_en = 1'b1; dir_down = 1'b1;
        enc_cycle_up();
        chk("R8 A edges only", count, 2);
        mode_sel = 3'd2;
        enc_cycle_up();
        chk("R8 B edges only", count, 4);
        enc_move(0, 1); enc_move(1, 1); enc_move(1, 0); enc_move(0, 0);
        chk("R8 B channel down", count, 2);
    endtask

    task automatic t_halt();
        do_reset();
        mode_sel = 3'd4; cnt_en = 1'b1;
        trig_in = 1'b1;
        enc_cycle_up();
        chk("R11 code 4 halts", count, 0);
        mode_sel = 3'd7; trig_in = 1'b0;
        enc_cycle_up();
        chk("R11 code 7 halts", count, 0);
    endtask

    initial begin
        #(200000 * 20);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_free_run();
        t_wrap();
        t_gated();
        t_triggered();
        t_quad();
        t_single_channel();
        t_halt();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule